// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a word-addressed down-counter that a single processor core uses as its private periodic or one-shot timer. Software loads a start value, picks a prescale ratio and a mode, and sets the run bit. The counter then steps down by one every (P+1) clock cycles. When it reaches its last step, the block raises a sticky event flag and emits a one-cycle interrupt pulse. In repeat mode the counter then refills from the load value. In single mode it parks at zero.

A small controller with three states drives the count. OFF means the run bit is clear and the count is frozen. PARK means the run bit is set but the count is zero, so nothing moves. RUN means the count is non-zero and steps on prescaler ticks. The next state is chosen from the next values of the run bit and the count:
- OFF→RUN on a run-bit rise with a non-zero count, or with a zero count refilled in repeat mode.
- OFF→PARK on a rise that leaves the count at zero.
- PARK→RUN on a non-zero write to the count.
- RUN→PARK on a single-mode expiry, or on a refill of zero.
- RUN→RUN on a repeat-mode refill or an ordinary step.
- Any state→OFF when the run bit is written low.

The bus port is synchronous on writes and combinational on reads. It has a 4-bit byte offset.

Top module: `cpu_countdown_timer`

## Requirements
- R1: After reset the load, counter, control and flag registers all read 0, and `irq` is low.
- R2: Register map: offset 0x0 is load, 0x4 is counter, 0x8 is control and 0xC is the event flag. In control, bit 0 is run, bit 1 is repeat mode and bits 15:8 are the prescale value P. All other control bits read 0. The flag is bit 0 of 0xC.
- R3: While running with count N, the count drops by one every P+1 cycles after the write or run-bit rise that started it. The expiry lands exactly N·(P+1) cycles after that edge.
- R4: A write to the load register also writes the same value into the counter and restarts the prescale phase.
- R5: In single mode, expiry sets the flag, leaves the counter at 0 and stops counting.
- R6: In repeat mode, expiry sets the flag and refills the counter from the load value, and counting continues.
- R7: Writing 0xC clears the flag where bit 0 of the data is 1. Writing 0 there leaves the flag unchanged.
- R8: `irq` is high for exactly one cycle, in the same cycle the flag goes from 0 to 1. An expiry while the flag is already 1 gives no pulse.
- R9: When the run bit rises while the counter is 0 and the written repeat bit is 1, the counter is first filled from the load value.
- R10: A counter read returns 0 while the run bit is clear. The count is held while stopped and resumes from the held value when the run bit rises again.
- R11: A zero counter with the run bit set stays at 0 and never sets the flag.
- R12: Offsets other than 0x0, 0x4, 0x8 and 0xC read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | One-cycle pulse on flag rise |

## Verification
A wrong count or prescale phase shows up on the very next counter read as a value that differs from N − ⌊t/(P+1)⌋. The bench reads the counter every cycle across a sweep of P and N, so such an error is caught within one cycle. A flag or controller state left wrong shows up at the expiry cycle: either `irq` fails to pulse there, or it pulses again on a later expiry without a clear in between. A missed refill shows up one period later as a parked count. A frozen-count fault appears on the first read after the run bit rises again.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        T_OFF  = 2'd0,
        T_PARK = 2'd1,
        T_RUN  = 2'd2
    } tmr_state_e;

    localparam logic [3:0] OFS_LOAD = 4'h0;
    localparam logic [3:0] OFS_CNT  = 4'h4;
    localparam logic [3:0] OFS_CTRL = 4'h8;
    localparam logic [3:0] OFS_STAT = 4'hC;
    localparam int unsigned PS_LSB  = 8;
endpackage

// File: rtl/tmr_bus.sv
module tmr_bus
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PS_W   = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              stat_q,
    output logic [DATA_W-1:0] load_q,
    output logic              en_q,
    output logic              auto_q,
    output logic [PS_W-1:0]   presc_q,
    output logic              cnt_wr,
    output logic [DATA_W-1:0] cnt_wval,
    output logic              en_rise,
    output logic              rise_auto,
    output logic              en_next,
    output logic              stat_clr
);
    localparam int unsigned PS_MSB = PS_LSB + PS_W - 1;

    logic sel_load, sel_cnt, sel_ctrl, sel_stat;
    logic [DATA_W-1:0] ctrl_view;

    always_comb begin
        sel_load = bus_wr && (bus_addr == ADDR_W'(OFS_LOAD));
        sel_cnt  = bus_wr && (bus_addr == ADDR_W'(OFS_CNT));
        sel_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        sel_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    end

    assign cnt_wr    = sel_load | sel_cnt;
    assign cnt_wval  = bus_wdata;
    assign en_rise   = sel_ctrl && bus_wdata[0] && !en_q;
    assign rise_auto = bus_wdata[1];
    assign en_next   = sel_ctrl ? bus_wdata[0] : en_q;
    assign stat_clr  = sel_stat && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= '0;
            en_q    <= 1'b0;
            auto_q  <= 1'b0;
            presc_q <= '0;
        end else begin
            if (sel_load) begin
                load_q <= bus_wdata;
            end
            if (sel_ctrl) begin
                en_q    <= bus_wdata[0];
                auto_q  <= bus_wdata[1];
                presc_q <= bus_wdata[PS_MSB:PS_LSB];
            end
        end
    end

    always_comb begin
        ctrl_view                = '0;
        ctrl_view[0]             = en_q;
        ctrl_view[1]             = auto_q;
        ctrl_view[PS_MSB:PS_LSB] = presc_q;
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_LOAD): bus_rdata = load_q;
            ADDR_W'(OFS_CNT):  bus_rdata = en_q ? cnt_q : '0;
            ADDR_W'(OFS_CTRL): bus_rdata = ctrl_view;
            ADDR_W'(OFS_STAT): bus_rdata = {{(DATA_W-1){1'b0}}, stat_q};
            default:           bus_rdata = '0;
        endcase
    end

    // R12: holes in the map read as zero
    assert_hole_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

    // R10: counter view is masked while stopped
    assert_stopped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && bus_addr == ADDR_W'(OFS_CNT)) |-> (bus_rdata == '0));
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic [PS_W-1:0] presc,
    output logic            tick
);
    logic [PS_W-1:0] pcnt_q;

    assign tick = run && (pcnt_q >= presc);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr || !run || tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R3: a fresh restart never ticks before the phase counter advances past zero unless P is zero
    assert_restart_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (pcnt_q == '0));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_next,
    input  logic             auto_q,
    input  logic             rise_auto,
    input  logic [CNT_W-1:0] load_q,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wval,
    input  logic             en_rise,
    input  logic             stat_clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             stat_q,
    output logic             irq,
    output logic             run
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    tmr_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_d;
    logic expire;
    logic stat_d;

    assign run = (st_q == T_RUN);

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        unique case (st_q)
            T_RUN: begin
                if (tick) begin
                    if (cnt_q == ONE) begin
                        expire = 1'b1;
                        cnt_d  = auto_q ? load_q : '0;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            T_PARK, T_OFF: begin
                cnt_d = cnt_q;
            end
            default: begin
                cnt_d = cnt_q;
            end
        endcase
        if (cnt_wr) begin
            cnt_d = cnt_wval;
        end else if (en_rise && rise_auto && cnt_q == '0) begin
            cnt_d = load_q;
        end
        if (!en_next) begin
            st_d = T_OFF;
        end else if (cnt_d != '0) begin
            st_d = T_RUN;
        end else begin
            st_d = T_PARK;
        end
        stat_d = (stat_q & ~stat_clr) | expire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= T_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            stat_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            stat_q <= stat_d;
            irq    <= stat_d & ~stat_q;
        end
    end

    // R8: pulse only on a fresh flag rise
    assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_q && !$past(stat_q)));

    // R3: each tick in RUN above one steps the count down by exactly one
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_RUN && tick && cnt_q > ONE && !cnt_wr) |=> (cnt_q == $past(cnt_q) - ONE));

    // R5: single-mode expiry parks at zero with the flag set
    assert_oneshot_parks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_RUN && tick && cnt_q == ONE && !auto_q && !cnt_wr) |=> (cnt_q == '0 && stat_q));

    // R10 and R11: outside RUN the count only moves by a bus write or a refill on rise
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != T_RUN && !cnt_wr && !en_rise) |=> $stable(cnt_q));

    // R11: a parked timer never raises the flag by itself
    assert_park_no_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_PARK && !stat_q) |=> !stat_q);
endmodule

// File: rtl/cpu_countdown_timer.sv
module cpu_countdown_timer #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PS_W   = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] cnt_q, load_q, cnt_wval;
    logic              stat_q, en_q, auto_q;
    logic [PS_W-1:0]   presc_q;
    logic              cnt_wr, en_rise, rise_auto, en_next, stat_clr;
    logic              run, tick;

    tmr_bus #(.DATA_W(DATA_W), .PS_W(PS_W), .ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_q     (cnt_q),
        .stat_q    (stat_q),
        .load_q    (load_q),
        .en_q      (en_q),
        .auto_q    (auto_q),
        .presc_q   (presc_q),
        .cnt_wr    (cnt_wr),
        .cnt_wval  (cnt_wval),
        .en_rise   (en_rise),
        .rise_auto (rise_auto),
        .en_next   (en_next),
        .stat_clr  (stat_clr)
    );

    tmr_prescale #(.PS_W(PS_W)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (cnt_wr | en_rise),
        .presc (presc_q),
        .tick  (tick)
    );

    tmr_core #(.CNT_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_next   (en_next),
        .auto_q    (auto_q),
        .rise_auto (rise_auto),
        .load_q    (load_q),
        .cnt_wr    (cnt_wr),
        .cnt_wval  (cnt_wval),
        .en_rise   (en_rise),
        .stat_clr  (stat_clr),
        .tick      (tick),
        .cnt_q     (cnt_q),
        .stat_q    (stat_q),
        .irq       (irq),
        .run       (run)
    );
endmodule

// File: tb/sim_cpu_countdown_timer.sv
`timescale 1ns/100ps
module sim_cpu_countdown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cpu_countdown_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'h0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.2;
        v = bus_rdata;
    endtask

    task automatic sweep(input int p, input int n);
        logic [31:0] v;
        int per;
        per = n * (p + 1);
        wr(4'h8, 32'((p << 8) | 1));
        wr(4'h4, 32'(n));
        for (int t = 0; t <= per + 1; t++) begin
            @(negedge clk);
            peek(4'h4, v);
            chk(v, (t < per) ? 32'(n - t / (p + 1)) : 32'h0, "R3 count step");
            peek(4'hC, v);
            chk(v, (t >= per) ? 32'h1 : 32'h0, "R5 flag");
            chk({31'h0, irq}, (t == per) ? 32'h1 : 32'h0, "R8 pulse");
            @(posedge clk);
        end
        wr(4'hC, 32'h0);
        @(negedge clk); peek(4'hC, v);
        chk(v, 32'h1, "R7 write zero keeps flag");
        wr(4'hC, 32'h1);
        @(negedge clk); peek(4'hC, v);
        chk(v, 32'h0, "R7 write one clears flag");
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        @(negedge clk);
        for (int a = 0; a < 16; a += 4) begin
            peek(4'(a), v);
            chk(v, 32'h0, "R1 reset read");
        end
        chk({31'h0, irq}, 32'h0, "R1 irq low");

        // R2 control layout
        wr(4'h8, 32'hFFFF_FFFE);
        @(negedge clk); peek(4'h8, v);
        chk(v, 32'h0000_FF02, "R2 control fields");
        wr(4'h8, 32'h0);

        // R12 holes
        wr(4'h0, 32'h55);
        wr(4'h5, 32'hDEAD_BEEF);
        wr(4'h2, 32'hFFFF_FFFF);
        wr(4'h9, 32'h3);
        @(negedge clk);
        peek(4'h0, v); chk(v, 32'h55, "R12 load untouched");
        peek(4'h8, v); chk(v, 32'h0, "R12 control untouched");
        peek(4'h1, v); chk(v, 32'h0, "R12 hole read");
        peek(4'hD, v); chk(v, 32'h0, "R12 hole read");
        peek(4'h7, v); chk(v, 32'h0, "R12 hole read");

        // R10 disabled view and frozen count
        wr(4'h4, 32'h0);
        wr(4'h8, 32'h1);
        wr(4'h4, 32'd10);
        @(negedge clk); peek(4'h4, v);
        chk(v, 32'd10, "R10 running start");
        wr(4'h8, 32'h0);
        @(negedge clk); peek(4'h4, v);
        chk(v, 32'h0, "R10 read zero when stopped");
        repeat (3) @(posedge clk);
        wr(4'h8, 32'h1);
        @(negedge clk); peek(4'h4, v);
        chk(v, 32'd8, "R10 held value resumes");
        wr(4'h8, 32'h0);

        // R4 load write overwrites the live count
        wr(4'h8, 32'h1);
        wr(4'h4, 32'd50);
        repeat (4) @(posedge clk);
        wr(4'h0, 32'd7);
        @(negedge clk);
        peek(4'h4, v); chk(v, 32'd7, "R4 counter follows load");
        peek(4'h0, v); chk(v, 32'd7, "R4 load value");
        wr(4'h8, 32'h0);

        // R11 zero count enabled does not run
        wr(4'h4, 32'h0);
        wr(4'h8, 32'h1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        peek(4'h4, v); chk(v, 32'h0, "R11 parked count");
        peek(4'hC, v); chk(v, 32'h0, "R11 no flag");
        wr(4'h8, 32'h0);

        // R9 refill on rise in repeat mode
        wr(4'h0, 32'd5);
        wr(4'h4, 32'h0);
        wr(4'h8, 32'h3);
        @(negedge clk); peek(4'h4, v);
        chk(v, 32'd5, "R9 refill on rise");
        wr(4'h8, 32'h0);

        // R3 R5 R8 sweep
        wr(4'hC, 32'h1);
        for (int p = 0; p < 4; p++)
            for (int n = 1; n <= 4; n++)
                sweep(p, n);
        sweep(255, 1);
        wr(4'h8, 32'h0);

        // R6 repeat mode, no refire while flag held
        wr(4'h0, 32'd3);
        wr(4'h8, 32'h0000_0103);
        for (int t = 0; t < 14; t++) begin
            @(negedge clk);
            peek(4'h4, v);
            chk(v, 32'(3 - (t % 6) / 2), "R6 repeat count");
            chk({31'h0, irq}, (t == 6) ? 32'h1 : 32'h0, "R8 no refire");
            @(posedge clk);
        end
        wr(4'hC, 32'h1);
        @(negedge clk); peek(4'hC, v);
        chk(v, 32'h0, "R7 clear in repeat mode");
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({31'h0, irq}, 32'h1, "R8 pulse after clear");
        peek(4'hC, v);
        chk(v, 32'h1, "R6 flag on next period");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule